// File: doc/BRIEF.md
# Management-Mode Memory Router

This block sits in the memory request path of a chipset, one stage after the request is seen. Each request carries an address, a read/write flag and a flag that is set while the processor runs in its system-management mode. The block decides whether the access goes to the private management store or to ordinary system memory. It also reports the memory type of the access (uncacheable, write-combining, write-through, write-protect or write-back) and a cache-enable qualifier.

The private window has a programmable base, a power-of-two size from 64 KiB to 4 MiB, and a programmable split offset. Offsets below the split form the shared region. That region overlaps memory the operating system also uses, so it is always reported uncacheable. Offsets at or above the split form the dedicated region, which only management code uses. Inside management mode that region may carry a cacheable type. A lock bit freezes the configuration until reset.

Memory-type codes used on every type port: UC = 0, WC = 1, WT = 4, WP = 5, WB = 6. Codes 2, 3 and 7 are not cacheable.

Top module: `mgmt_mem_router`

## Requirements
- R1: After reset, rspValid, rspToPriv, rspWrite, rspCacheEn and rspMemType are all 0. The configuration is unlocked, with base 0xA000_0000, size exponent 16 (64 KiB), split 0x8000, dedicated type WB and default type WB.
- R2: A request presented on reqValid at a clock edge produces rspValid high after exactly that edge, with rspWrite equal to reqWrite. In a cycle without reqValid, rspValid is low and rspToPriv, rspWrite, rspMemType and rspCacheEn keep their values.
- R3: A request with reqInMgmt high whose address lies inside the window gives rspToPriv = 1. An address outside the window gives rspToPriv = 0 in every mode.
- R4: A request with reqInMgmt low always gives rspToPriv = 0.
- R5: An address inside the window whose offset is below the split reports UC (0) with rspCacheEn = 0, in either mode.
- R6: An address inside the window at or above the split, requested in management mode, reports the programmed dedicated type when that type is WT (4), WP (5) or WB (6), and UC (0) for any other programmed code.
- R7: An address in the dedicated region requested outside management mode reports UC (0).
- R8: An address outside the window reports the programmed default type unchanged, whatever its code.
- R9: rspCacheEn is 1 only when the reported type is WT, WP or WB. WC (1) and UC (0) give 0.
- R10: A configuration write takes effect only if the size exponent is in 16..22, the base has no bits set below 2^size, and the split is no larger than 2^size. Any other write leaves the whole configuration unchanged. A request presented in the same cycle as an accepted write still uses the old configuration; a request one cycle later uses the new one.
- R11: An accepted write with cfgLock high applies its values and sets the lock. While the lock is set, every configuration write is ignored. Only reset clears the lock.
- R12: The window covers base through base + 2^size - 1. The byte at base + 2^size lies outside it. Offset split - 1 is shared and offset split is dedicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgBase | input | ADDR_W | Window base address |
| cfgSizeLog2 | input | LOG_W | Window size exponent |
| cfgSplit | input | SPLIT_W | Offset where the dedicated region starts |
| cfgDedType | input | 3 | Memory type for the dedicated region in management mode |
| cfgSysType | input | 3 | Memory type outside the window |
| cfgLock | input | 1 | Set the lock together with this write |
| reqValid | input | 1 | Request valid |
| reqAddr | input | ADDR_W | Request address |
| reqWrite | input | 1 | Request is a write |
| reqInMgmt | input | 1 | Processor is in management mode |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspToPriv | output | 1 | 1 = private management store, 0 = system memory |
| rspWrite | output | 1 | Registered copy of reqWrite |
| rspMemType | output | 3 | Reported memory type |
| rspCacheEn | output | 1 | Cache-enable qualifier |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and a size exponent range of 16 to 22. These defaults let both extremes of window size be reached, the 64 KiB reset window and a programmed 4 MiB window. The split, window-end and one-past-end addresses can then be probed for both window sizes, and illegal exponents 15 and 23 can be tried as rejected writes. With a 23-bit split field, a split one above the 4 MiB size can be driven, which exercises the split-range rejection.

// File: rtl/mmr_pkg.sv
package mmr_pkg;

  localparam logic [2:0] MT_UC = 3'd0;
  localparam logic [2:0] MT_WC = 3'd1;
  localparam logic [2:0] MT_WT = 3'd4;
  localparam logic [2:0] MT_WP = 3'd5;
  localparam logic [2:0] MT_WB = 3'd6;

  typedef struct packed {
    logic loadCfg;
    logic takeReq;
    logic locked;
  } mmr_strb_t;

  function automatic logic mtCacheable(input logic [2:0] t);
    return (t == MT_WT) || (t == MT_WP) || (t == MT_WB);
  endfunction

endpackage

// File: rtl/mmr_ctrl.sv
module mmr_ctrl
  import mmr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 16,
  parameter int MAX_LOG2 = 22,
  localparam int LOG_W   = $clog2(MAX_LOG2 + 1),
  localparam int SPLIT_W = MAX_LOG2 + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [LOG_W-1:0]   cfgSizeLog2,
  input  logic [SPLIT_W-1:0] cfgSplit,
  input  logic               cfgLock,
  input  logic               reqValid,
  output mmr_strb_t          strb
);

  logic               lockedQ;
  logic [ADDR_W-1:0]  lowMask;
  logic [SPLIT_W-1:0] sizeBytes;
  logic               sizeOk, alignOk, splitOk, cfgLegal, loadNow;

  // Bits below the requested size exponent must be clear in the base.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_lowMask
    assign lowMask[i] = (int'(cfgSizeLog2) > i);
  end

  always_comb begin
    sizeOk    = (int'(cfgSizeLog2) >= MIN_LOG2) && (int'(cfgSizeLog2) <= MAX_LOG2);
    sizeBytes = SPLIT_W'(1) << cfgSizeLog2;
    alignOk   = (cfgBase & lowMask) == '0;
    splitOk   = cfgSplit <= sizeBytes;
    cfgLegal  = sizeOk && alignOk && splitOk;
    loadNow   = cfgWrEn && !lockedQ && cfgLegal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lockedQ <= 1'b0;
    else if (loadNow && cfgLock) lockedQ <= 1'b1;
  end

  assign strb.loadCfg = loadNow;
  assign strb.takeReq = reqValid;
  assign strb.locked  = lockedQ;

  // R11: once set, the lock stays until reset
  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ |=> lockedQ);

  // R11: the lock only rises after a write that asked for it
  p_lock_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedQ) |-> $past(cfgWrEn && cfgLock));

endmodule

// File: rtl/mmr_datapath.sv
module mmr_datapath
  import mmr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 16,
  parameter int MAX_LOG2 = 22,
  localparam int LOG_W   = $clog2(MAX_LOG2 + 1),
  localparam int SPLIT_W = MAX_LOG2 + 1,
  parameter logic [ADDR_W-1:0]  RST_BASE     = 'hA000_0000,
  parameter logic [LOG_W-1:0]   RST_LOG2     = 16,
  parameter logic [SPLIT_W-1:0] RST_SPLIT    = 'h8000,
  parameter logic [2:0]         RST_DED_TYPE = 3'd6,
  parameter logic [2:0]         RST_SYS_TYPE = 3'd6
) (
  input  logic               clk,
  input  logic               rstN,
  input  mmr_strb_t          strb,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [LOG_W-1:0]   cfgSizeLog2,
  input  logic [SPLIT_W-1:0] cfgSplit,
  input  logic [2:0]         cfgDedType,
  input  logic [2:0]         cfgSysType,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqWrite,
  input  logic               reqInMgmt,
  output logic               rspValid,
  output logic               rspToPriv,
  output logic               rspWrite,
  output logic [2:0]         rspMemType,
  output logic               rspCacheEn
);

  logic [ADDR_W-1:0]  baseQ;
  logic [LOG_W-1:0]   sizeLog2Q;
  logic [SPLIT_W-1:0] splitQ;
  logic [2:0]         dedTypeQ, sysTypeQ;

  logic [ADDR_W-1:0]  winMask;
  logic [SPLIT_W-1:0] offset;
  logic               inWin, inShared, dedOk, toPrivNext;
  logic [2:0]         typeNext;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ     <= RST_BASE;
      sizeLog2Q <= RST_LOG2;
      splitQ    <= RST_SPLIT;
      dedTypeQ  <= RST_DED_TYPE;
      sysTypeQ  <= RST_SYS_TYPE;
    end else if (strb.loadCfg) begin
      baseQ     <= cfgBase;
      sizeLog2Q <= cfgSizeLog2;
      splitQ    <= cfgSplit;
      dedTypeQ  <= cfgDedType;
      sysTypeQ  <= cfgSysType;
    end
  end

  // Window decode
  for (genvar i = 0; i < ADDR_W; i++) begin : g_winMask
    assign winMask[i] = (int'(sizeLog2Q) > i);
  end

  always_comb begin
    inWin    = ((reqAddr ^ baseQ) & ~winMask) == '0;
    offset   = reqAddr[SPLIT_W-1:0] & winMask[SPLIT_W-1:0];
    inShared = offset < splitQ;
    dedOk    = mtCacheable(dedTypeQ);
    toPrivNext = inWin && reqInMgmt;
    if (!inWin)                     typeNext = sysTypeQ;
    else if (reqInMgmt && !inShared) typeNext = dedOk ? dedTypeQ : MT_UC;
    else                            typeNext = MT_UC;
  end

  // Response stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspToPriv  <= 1'b0;
      rspWrite   <= 1'b0;
      rspMemType <= MT_UC;
      rspCacheEn <= 1'b0;
    end else begin
      rspValid <= strb.takeReq;
      if (strb.takeReq) begin
        rspToPriv  <= toPrivNext;
        rspWrite   <= reqWrite;
        rspMemType <= typeNext;
        rspCacheEn <= mtCacheable(typeNext);
      end
    end
  end

  // R2: one cycle from request to response
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R2: idle cycles keep the response fields
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && $stable(rspToPriv) && $stable(rspMemType) && $stable(rspCacheEn)));

  // R4: no private routing outside management mode
  p_priv_needs_mgmt_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqInMgmt) |=> !rspToPriv);

  // R9: UC and WC never enable caching
  p_no_cache_uc_wc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspMemType == MT_UC || rspMemType == MT_WC) |-> !rspCacheEn);

  // R10: stored configuration is always a legal one
  p_cfg_legal_r10: assert property (@(posedge clk) disable iff (!rstN)
    (int'(sizeLog2Q) >= MIN_LOG2 && int'(sizeLog2Q) <= MAX_LOG2
     && (baseQ & winMask) == '0 && splitQ <= (SPLIT_W'(1) << sizeLog2Q)));

  // R11: no configuration change while locked
  p_lock_freeze_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.locked |=> ($stable(baseQ) && $stable(sizeLog2Q) && $stable(splitQ)
                     && $stable(dedTypeQ) && $stable(sysTypeQ)));

endmodule

// File: rtl/mgmt_mem_router.sv
module mgmt_mem_router
  import mmr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG2 = 16,
  parameter int MAX_LOG2 = 22,
  localparam int LOG_W   = $clog2(MAX_LOG2 + 1),
  localparam int SPLIT_W = MAX_LOG2 + 1,
  parameter logic [ADDR_W-1:0]  RST_BASE     = 'hA000_0000,
  parameter logic [LOG_W-1:0]   RST_LOG2     = 16,
  parameter logic [SPLIT_W-1:0] RST_SPLIT    = 'h8000,
  parameter logic [2:0]         RST_DED_TYPE = 3'd6,
  parameter logic [2:0]         RST_SYS_TYPE = 3'd6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [LOG_W-1:0]   cfgSizeLog2,
  input  logic [SPLIT_W-1:0] cfgSplit,
  input  logic [2:0]         cfgDedType,
  input  logic [2:0]         cfgSysType,
  input  logic               cfgLock,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqWrite,
  input  logic               reqInMgmt,
  output logic               rspValid,
  output logic               rspToPriv,
  output logic               rspWrite,
  output logic [2:0]         rspMemType,
  output logic               rspCacheEn
);

  mmr_strb_t strb;

  mmr_ctrl #(
    .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgBase(cfgBase),
    .cfgSizeLog2(cfgSizeLog2), .cfgSplit(cfgSplit), .cfgLock(cfgLock),
    .reqValid(reqValid), .strb(strb)
  );

  mmr_datapath #(
    .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2),
    .RST_BASE(RST_BASE), .RST_LOG2(RST_LOG2), .RST_SPLIT(RST_SPLIT),
    .RST_DED_TYPE(RST_DED_TYPE), .RST_SYS_TYPE(RST_SYS_TYPE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgBase(cfgBase),
    .cfgSizeLog2(cfgSizeLog2), .cfgSplit(cfgSplit), .cfgDedType(cfgDedType),
    .cfgSysType(cfgSysType), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqInMgmt(reqInMgmt), .rspValid(rspValid),
    .rspToPriv(rspToPriv), .rspWrite(rspWrite), .rspMemType(rspMemType),
    .rspCacheEn(rspCacheEn)
  );

endmodule

// File: tb/mgmt_mem_router_tb.sv
module mgmt_mem_router_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic        mgmt;
    logic        toPriv;
    logic [2:0]  mt;
    logic        ce;
  } vec_t;

  // Reset configuration: base A000_0000, 64 KiB, split 0x8000, dedicated WB, default WB
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{32'hA000_0000, 1'b1, 1'b1, 3'd0, 1'b0},  // R3 R5 first shared byte
    '{32'hA000_7FFF, 1'b1, 1'b1, 3'd0, 1'b0},  // R12 split-1 shared
    '{32'hA000_8000, 1'b1, 1'b1, 3'd6, 1'b1},  // R6 R12 split is dedicated
    '{32'hA000_FFFF, 1'b1, 1'b1, 3'd6, 1'b1},  // R12 last window byte
    '{32'hA001_0000, 1'b1, 1'b0, 3'd6, 1'b1},  // R8 R12 one past end
    '{32'h9FFF_FFFF, 1'b1, 1'b0, 3'd6, 1'b1},  // R3 below base
    '{32'hA000_0000, 1'b0, 1'b0, 3'd0, 1'b0},  // R4 R5 shared, normal mode
    '{32'hA000_8000, 1'b0, 1'b0, 3'd0, 1'b0},  // R7 dedicated, normal mode
    '{32'hA000_FFFF, 1'b0, 1'b0, 3'd0, 1'b0},  // R7
    '{32'h1234_5678, 1'b0, 1'b0, 3'd6, 1'b1}   // R8
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn, cfgLock;
  logic [31:0] cfgBase;
  logic [4:0]  cfgSizeLog2;
  logic [22:0] cfgSplit;
  logic [2:0]  cfgDedType, cfgSysType;
  logic        reqValid, reqWrite, reqInMgmt;
  logic [31:0] reqAddr;
  logic        rspValid, rspToPriv, rspWrite, rspCacheEn;
  logic [2:0]  rspMemType;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_mem_router u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgBase(cfgBase),
    .cfgSizeLog2(cfgSizeLog2), .cfgSplit(cfgSplit), .cfgDedType(cfgDedType),
    .cfgSysType(cfgSysType), .cfgLock(cfgLock), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqInMgmt(reqInMgmt),
    .rspValid(rspValid), .rspToPriv(rspToPriv), .rspWrite(rspWrite),
    .rspMemType(rspMemType), .rspCacheEn(rspCacheEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present one request at a falling edge, sample the response at the next falling edge.
  task automatic sendReq(input logic [31:0] a, input logic mgmt, input logic wr);
    reqValid = 1'b1; reqAddr = a; reqInMgmt = mgmt; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectRsp(input string tag, input logic toPriv, input logic [2:0] mt, input logic ce);
    chk({tag, " valid"}, 32'(rspValid), 32'd1);
    chk({tag, " route"}, 32'(rspToPriv), 32'(toPriv));
    chk({tag, " type"}, 32'(rspMemType), 32'(mt));
    chk({tag, " cache"}, 32'(rspCacheEn), 32'(ce));
  endtask

  task automatic cfgWrite(input logic [31:0] b, input logic [4:0] l2, input logic [22:0] sp,
                          input logic [2:0] dt, input logic [2:0] st, input logic lk);
    cfgWrEn = 1'b1; cfgBase = b; cfgSizeLog2 = l2; cfgSplit = sp;
    cfgDedType = dt; cfgSysType = st; cfgLock = lk;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgLock = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgLock = 1'b0; cfgBase = '0; cfgSizeLog2 = '0;
    cfgSplit = '0; cfgDedType = '0; cfgSysType = '0;
    reqValid = 1'b0; reqAddr = '0; reqWrite = 1'b0; reqInMgmt = 1'b0;
    @(negedge clk);
    doReset();

    // R1 reset outputs
    chk("R1 valid", 32'(rspValid), 0);
    chk("R1 route", 32'(rspToPriv), 0);
    chk("R1 write", 32'(rspWrite), 0);
    chk("R1 type", 32'(rspMemType), 0);
    chk("R1 cache", 32'(rspCacheEn), 0);

    // Table walk on the reset configuration
    for (int i = 0; i < NVEC; i++) begin
      sendReq(VECS[i].addr, VECS[i].mgmt, 1'b0);
      expectRsp($sformatf("R3/R12 vec%0d", i), VECS[i].toPriv, VECS[i].mt, VECS[i].ce);
    end

    // R2 write echo and hold on idle
    sendReq(32'hA000_8000, 1'b1, 1'b1);
    chk("R2 write echo", 32'(rspWrite), 1);
    @(negedge clk);
    chk("R2 idle valid", 32'(rspValid), 0);
    chk("R2 idle hold route", 32'(rspToPriv), 1);
    chk("R2 idle hold type", 32'(rspMemType), 6);
    chk("R2 idle hold write", 32'(rspWrite), 1);

    // R2 back-to-back requests
    reqValid = 1'b1; reqAddr = 32'hA000_8000; reqInMgmt = 1'b1; reqWrite = 1'b0;
    @(negedge clk);
    chk("R2 b2b first route", 32'(rspToPriv), 1);
    reqAddr = 32'hA000_0000; reqInMgmt = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 b2b second valid", 32'(rspValid), 1);
    chk("R2 b2b second route", 32'(rspToPriv), 0);

    // R10 legal write: 4 MiB window at 0x0040_0000, split 0x10_0000, dedicated WP, default WC
    cfgWrite(32'h0040_0000, 5'd22, 23'h10_0000, 3'd5, 3'd1, 1'b0);
    sendReq(32'h0040_0000, 1'b1, 1'b0); expectRsp("R10 R5 new shared", 1'b1, 3'd0, 1'b0);
    sendReq(32'h0050_0000, 1'b1, 1'b0); expectRsp("R10 R6 new dedicated WP", 1'b1, 3'd5, 1'b1);
    sendReq(32'h007F_FFFF, 1'b1, 1'b0); expectRsp("R12 4MiB last byte", 1'b1, 3'd5, 1'b1);
    sendReq(32'h0080_0000, 1'b1, 1'b0); expectRsp("R9 R12 past end WC", 1'b0, 3'd1, 1'b0);
    sendReq(32'hA000_8000, 1'b1, 1'b0); expectRsp("R10 old window gone", 1'b0, 3'd1, 1'b0);

    // R10 illegal writes are ignored as a whole
    cfgWrite(32'h0041_0000, 5'd22, 23'h10_0000, 3'd6, 3'd6, 1'b0);
    sendReq(32'h0050_0000, 1'b1, 1'b0); expectRsp("R10 misaligned ignored", 1'b1, 3'd5, 1'b1);
    cfgWrite(32'h0040_0000, 5'd15, 23'h0, 3'd6, 3'd6, 1'b0);
    sendReq(32'h0050_0000, 1'b1, 1'b0); expectRsp("R10 size15 ignored", 1'b1, 3'd5, 1'b1);
    cfgWrite(32'h0000_0000, 5'd23, 23'h0, 3'd6, 3'd6, 1'b0);
    sendReq(32'h0050_0000, 1'b1, 1'b0); expectRsp("R10 size23 ignored", 1'b1, 3'd5, 1'b1);
    cfgWrite(32'h0040_0000, 5'd22, 23'h40_0001, 3'd6, 3'd6, 1'b0);
    sendReq(32'h0050_0000, 1'b1, 1'b0); expectRsp("R10 split too big ignored", 1'b1, 3'd5, 1'b1);

    // R6 dedicated programmed as WC reports UC; default UC
    cfgWrite(32'h0040_0000, 5'd22, 23'h0, 3'd1, 3'd0, 1'b0);
    sendReq(32'h0040_0000, 1'b1, 1'b0); expectRsp("R6 ded WC gives UC", 1'b1, 3'd0, 1'b0);
    sendReq(32'h0100_0000, 1'b0, 1'b0); expectRsp("R8 R9 default UC", 1'b0, 3'd0, 1'b0);

    // R11 lock applies its own write, then freezes
    cfgWrite(32'h2000_0000, 5'd16, 23'h8000, 3'd4, 3'd6, 1'b1);
    sendReq(32'h2000_8000, 1'b1, 1'b0); expectRsp("R11 locked write applied WT", 1'b1, 3'd4, 1'b1);
    cfgWrite(32'h3000_0000, 5'd16, 23'h8000, 3'd6, 3'd6, 1'b0);
    sendReq(32'h2000_8000, 1'b1, 1'b0); expectRsp("R11 write ignored old kept", 1'b1, 3'd4, 1'b1);
    sendReq(32'h3000_8000, 1'b1, 1'b0); expectRsp("R11 write ignored new absent", 1'b0, 3'd6, 1'b1);

    // R1 R11 reset restores defaults and clears the lock
    doReset();
    sendReq(32'hA000_8000, 1'b1, 1'b0); expectRsp("R1 defaults after reset", 1'b1, 3'd6, 1'b1);

    // R10 same-cycle write and request: old configuration, then new one
    cfgWrEn = 1'b1; cfgBase = 32'h2000_0000; cfgSizeLog2 = 5'd16; cfgSplit = 23'h8000;
    cfgDedType = 3'd5; cfgSysType = 3'd1; cfgLock = 1'b0;
    reqValid = 1'b1; reqAddr = 32'hA000_8000; reqInMgmt = 1'b1; reqWrite = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    expectRsp("R10 same cycle uses old", 1'b1, 3'd6, 1'b1);
    sendReq(32'hA000_8000, 1'b1, 1'b0); expectRsp("R10 R11 next cycle uses new", 1'b0, 3'd1, 1'b0);
    sendReq(32'h2000_8000, 1'b1, 1'b0); expectRsp("R11 unlocked after reset", 1'b1, 3'd5, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule